// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block places three byte-wide parallel ports (A, B and C) behind a small register interface. The bus uses a chip select, read and write strobes, and a two-bit address. A write to the control address does one of two things. It can redefine the direction and operating mode of every port group, or it can set or clear one bit of port C without touching the others. Port C is split into two nibbles. The upper nibble goes with port A and the lower nibble goes with port B. Each nibble has its own direction.

Each group runs in one of two modes. In plain mode a port is either a latched output or a live, unlatched input. In handshake mode, ports A and B borrow port C lines as a strobe or acknowledge input and a status flag output. On an input channel, the strobe captures the port data and the CPU read releases the flag. On an output channel, the CPU write raises a data-pending flag and the peripheral acknowledge clears it.

Each pin is modelled as three separate signals: an input, an output and an output enable. All bus activity is synchronous to the system clock. Read data appears one cycle after the read is sampled.

Top module: `pario_port`

## Requirements
- R1: After reset every output enable is 0 (all ports input), port A and B output latches are 0, and the read data bus is 0x00.
- R2: A control write with data bit 7 = 1 is a mode word. Bit 4 sets the port A direction, bit 3 the port C upper direction, bit 1 the port B direction and bit 0 the port C lower direction, with 1 meaning input. The output enables follow from the next cycle.
- R3: A mode word clears the port A, B and C output latches to zero.
- R4: In plain mode, a write to an output port (address 0 = A, 1 = B, 2 = C) updates its pins on the next cycle, and a read returns the latched value.
- R5: In plain mode, a read of an input port returns the pin value present in the read cycle, with no latching.
- R6: A control write with bit 7 = 0 changes only port C latch bit number data[3:1] to the value data[0], and leaves the port configuration unchanged.
- R7: The port C nibbles follow their own directions. A read of port C returns the driven value on output-enabled bits and the pin value on the other bits.
- R8: The control register is write-only. A read of address 3 returns 0x00.
- R9: A read or write with chip select low has no effect. This covers both the port latches and the read data bus.
- R10: Group A handshake input (data bits 6-5 not 00, port A input): a falling edge on pin C4 latches port A and drives a buffer-full flag high on C5. A read of port A returns the latched byte, clears the flag, and CPU writes to port A are ignored.
- R11: Group B handshake input (data bit 2 = 1, port B input): a falling edge on pin C2 latches port B and drives the buffer-full flag high on C1. A read of port B clears it.
- R12: Handshake output: a CPU write to port A (or B) drives the active-low data-pending flag low on C7 (or C1). A falling edge on the acknowledge pin C6 (or C2) drives it high again.
- R13: Read data is registered. It appears on the cycle after the read strobe is sampled and holds until the next selected read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | 2 | 0 port A, 1 port B, 2 port C, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A pin output value |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B pin output value |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C pin output value |
| pc_oe | output | 8 | Port C output enable |

## Verification
Each kind of wrong internal state shows up at the pins within one cycle:

- A corrupted configuration appears as wrong output-enable patterns on the cycle after the control write, and the bench compares those enables directly.
- A bit set/reset that disturbs a neighbour bit, or a mode word that leaves a stale latch, is visible on the port C or port A/B outputs one cycle after the write.
- A handshake flag stuck or inverted shows on its port C line one cycle after the strobe, acknowledge or CPU access that should have moved it.
- Wrongly captured handshake data is exposed by the next port read, one cycle later on the read bus.

// File: rtl/pario_pkg.sv
package pario_pkg;
  localparam int DW    = 8;
  localparam int IDX_W = $clog2(DW);

  // handshake pin positions on port C
  localparam int A_STB  = 4;
  localparam int A_IBF  = 5;
  localparam int A_ACK  = 6;
  localparam int A_OBF  = 7;
  localparam int B_STB  = 2;
  localparam int B_FLAG = 1;

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } sel_e;

  // field order matches control word bits 6..0
  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                 b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/pario_ctrl.sv
module pario_ctrl
  import pario_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctl,
  input  logic [DW-1:0]    wdata,
  output cfg_t             cfg,
  output logic             mode_load,
  output logic             bsr_hit,
  output logic [IDX_W-1:0] bsr_idx,
  output logic             bsr_val
);
  assign mode_load = wr_ctl & wdata[7];
  assign bsr_hit   = wr_ctl & ~wdata[7];
  assign bsr_idx   = wdata[IDX_W:1];
  assign bsr_val   = wdata[0];

  always_ff @(posedge clk) begin
    if (rst)            cfg <= CFG_RESET;
    else if (mode_load) cfg <= cfg_t'(wdata[6:0]);
  end

  // R6: a bit set/reset command leaves the configuration alone
  assert_bsr_keeps_cfg_R6: assert property (@(posedge clk) disable iff (rst)
    bsr_hit |=> $stable(cfg));
endmodule

// File: rtl/pario_hs_chan.sv
module pario_hs_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         hs_en,
  input  logic         dir_in,
  input  logic [W-1:0] pin_in,
  input  logic         hs_pin,
  input  logic         cpu_wr,
  input  logic         cpu_rd,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] rd_val,
  output logic         ibf,
  output logic         obf_n
);
  logic hs_prev;
  logic fall;

  assign fall   = hs_prev & ~hs_pin;
  assign rd_val = (dir_in && !hs_en) ? pin_in : data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      ibf     <= 1'b0;
      obf_n   <= 1'b1;
      hs_prev <= 1'b1;
    end else begin
      hs_prev <= hs_pin;
      if (clr) begin
        data_q <= '0;
        ibf    <= 1'b0;
        obf_n  <= 1'b1;
      end else begin
        if (hs_en && dir_in) begin
          if (fall) begin
            data_q <= pin_in;
            ibf    <= 1'b1;
          end else if (cpu_rd) begin
            ibf <= 1'b0;
          end
        end else if (cpu_wr) begin
          data_q <= wdata;
        end
        if (hs_en && !dir_in) begin
          if (cpu_wr)    obf_n <= 1'b0;
          else if (fall) obf_n <= 1'b1;
        end
      end
    end
  end

  // R10 R11: strobe edge captures data and raises buffer full
  assert_strobe_sets_ibf_R10: assert property (@(posedge clk) disable iff (rst)
    (hs_en && dir_in && fall && !clr) |=> (ibf && data_q == $past(pin_in)));
  assert_read_clears_ibf_R11: assert property (@(posedge clk) disable iff (rst)
    (hs_en && dir_in && cpu_rd && !fall && !clr) |=> !ibf);
  // R12: CPU write marks output data pending
  assert_write_sets_obf_R12: assert property (@(posedge clk) disable iff (rst)
    (hs_en && !dir_in && cpu_wr && !clr) |=> !obf_n);
endmodule

// File: rtl/pario_cport.sv
module pario_cport
  import pario_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  cfg_t             cfg,
  input  logic             mode_load,
  input  logic             bsr_hit,
  input  logic [IDX_W-1:0] bsr_idx,
  input  logic             bsr_val,
  input  logic             wr_c,
  input  logic [DW-1:0]    wdata,
  input  logic             ibf_a,
  input  logic             obf_n_a,
  input  logic             ibf_b,
  input  logic             obf_n_b,
  input  logic [DW-1:0]    pc_in,
  output logic [DW-1:0]    pc_out,
  output logic [DW-1:0]    pc_oe,
  output logic [DW-1:0]    pc_rd,
  output logic             stb_a,
  output logic             stb_b
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] lat;
  logic          a_hs;
  logic          b_hs;

  assign a_hs = |cfg.a_mode;
  assign b_hs = cfg.b_mode;

  always_ff @(posedge clk) begin
    if (rst)            lat <= '0;
    else if (mode_load) lat <= '0;
    else if (bsr_hit)   lat[bsr_idx] <= bsr_val;
    else if (wr_c)      lat <= wdata;
  end

  always_comb begin
    pc_oe  = {{HALF{~cfg.cu_in}}, {HALF{~cfg.cl_in}}};
    pc_out = lat;
    if (a_hs) begin
      if (cfg.a_in) begin
        pc_oe[A_STB]  = 1'b0;
        pc_oe[A_IBF]  = 1'b1;
        pc_out[A_IBF] = ibf_a;
      end else begin
        pc_oe[A_ACK]  = 1'b0;
        pc_oe[A_OBF]  = 1'b1;
        pc_out[A_OBF] = obf_n_a;
      end
    end
    if (b_hs) begin
      pc_oe[B_STB]   = 1'b0;
      pc_oe[B_FLAG]  = 1'b1;
      pc_out[B_FLAG] = cfg.b_in ? ibf_b : obf_n_b;
    end
  end

  assign pc_rd = (pc_oe & pc_out) | (~pc_oe & pc_in);
  assign stb_a = cfg.a_in ? pc_in[A_STB] : pc_in[A_ACK];
  assign stb_b = pc_in[B_STB];

  // R6: set/reset hits the addressed bit and nothing else
  assert_bsr_single_bit_R6: assert property (@(posedge clk) disable iff (rst)
    bsr_hit |=> (lat[$past(bsr_idx)] == $past(bsr_val) &&
                 $countones(lat ^ $past(lat)) <= 1));
endmodule

// File: rtl/pario_port.sv
module pario_port
  import pario_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  sel_e             sel;
  logic             wr_hit, rd_hit;
  cfg_t             cfg;
  logic             mode_load, bsr_hit, bsr_val;
  logic [IDX_W-1:0] bsr_idx;
  logic [DW-1:0]    rd_a, rd_b, rd_c;
  logic             ibf_a, obf_n_a, ibf_b, obf_n_b;
  logic             stb_a, stb_b;

  assign sel    = sel_e'(bus_addr);
  assign wr_hit = bus_cs & bus_wr;
  assign rd_hit = bus_cs & bus_rd;

  pario_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ctl(wr_hit && sel == SEL_CTL), .wdata(bus_wdata),
    .cfg(cfg), .mode_load(mode_load), .bsr_hit(bsr_hit),
    .bsr_idx(bsr_idx), .bsr_val(bsr_val)
  );

  pario_hs_chan #(.W(DW)) u_cha (
    .clk(clk), .rst(rst), .clr(mode_load), .hs_en(|cfg.a_mode), .dir_in(cfg.a_in),
    .pin_in(pa_in), .hs_pin(stb_a),
    .cpu_wr(wr_hit && sel == SEL_A), .cpu_rd(rd_hit && sel == SEL_A),
    .wdata(bus_wdata), .data_q(pa_out), .rd_val(rd_a),
    .ibf(ibf_a), .obf_n(obf_n_a)
  );

  pario_hs_chan #(.W(DW)) u_chb (
    .clk(clk), .rst(rst), .clr(mode_load), .hs_en(cfg.b_mode), .dir_in(cfg.b_in),
    .pin_in(pb_in), .hs_pin(stb_b),
    .cpu_wr(wr_hit && sel == SEL_B), .cpu_rd(rd_hit && sel == SEL_B),
    .wdata(bus_wdata), .data_q(pb_out), .rd_val(rd_b),
    .ibf(ibf_b), .obf_n(obf_n_b)
  );

  pario_cport u_cport (
    .clk(clk), .rst(rst), .cfg(cfg), .mode_load(mode_load),
    .bsr_hit(bsr_hit), .bsr_idx(bsr_idx), .bsr_val(bsr_val),
    .wr_c(wr_hit && sel == SEL_C), .wdata(bus_wdata),
    .ibf_a(ibf_a), .obf_n_a(obf_n_a), .ibf_b(ibf_b), .obf_n_b(obf_n_b),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe), .pc_rd(rd_c),
    .stb_a(stb_a), .stb_b(stb_b)
  );

  assign pa_oe = {DW{~cfg.a_in}};
  assign pb_oe = {DW{~cfg.b_in}};

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_hit) begin
      case (sel)
        SEL_A:   bus_rdata <= rd_a;
        SEL_B:   bus_rdata <= rd_b;
        SEL_C:   bus_rdata <= rd_c;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_reset_inputs_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pa_oe == 0 && pb_oe == 0 && pc_oe == 0 && bus_rdata == 0));
  assert_mode_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && sel == SEL_CTL && bus_wdata[7]) |=> (pa_out == 0 && pb_out == 0));
  assert_ctl_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && sel == SEL_CTL) |=> bus_rdata == 0);
  assert_no_cs_no_read_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_cs |=> $stable(bus_rdata));
endmodule

// File: tb/sim_pario_port.sv
`timescale 1ns/1ps
module sim_pario_port;
  logic       clk = 1'b0;
  logic       rst;
  logic       cs, rd, wr;
  logic [1:0] addr;
  logic [7:0] wd, rdata;
  logic [7:0] pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe, pc_in, pc_out, pc_oe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pario_port u0 (
    .clk(clk), .rst(rst), .bus_cs(cs), .bus_rd(rd), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk); cs = sel; wr = 1'b1; addr = a; wd = d;
    @(negedge clk); cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk); cs = sel; rd = 1'b1; addr = a;
    @(negedge clk); cs = 1'b0; rd = 1'b0; d = rdata;
  endtask

  task automatic pulse_c(input int bit_no);
    @(negedge clk); pc_in[bit_no] = 1'b0;
    @(negedge clk);
  endtask

  task automatic release_c(input int bit_no);
    @(negedge clk); pc_in[bit_no] = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
  endtask

  task automatic t_plain_out();
    logic [7:0] d;
    bus_write(2'd3, 8'h80);
    chk("R2 pa_oe", pa_oe, 8'hFF);
    chk("R2 pb_oe", pb_oe, 8'hFF);
    chk("R2 pc_oe", pc_oe, 8'hFF);
    bus_write(2'd0, 8'h5A);
    bus_write(2'd1, 8'hC3);
    bus_write(2'd2, 8'h96);
    chk("R4 pa_out", pa_out, 8'h5A);
    chk("R4 pb_out", pb_out, 8'hC3);
    chk("R4 pc_out", pc_out, 8'h96);
    bus_read(2'd0, d);
    chk("R4 R13 read A", d, 8'h5A);
    repeat (2) @(negedge clk);
    chk("R13 rdata holds", rdata, 8'h5A);
    bus_read(2'd2, d);
    chk("R7 read C out", d, 8'h96);
  endtask

  task automatic t_mode_clear();
    bus_write(2'd3, 8'h80);
    chk("R3 pa_out", pa_out, 8'h00);
    chk("R3 pb_out", pb_out, 8'h00);
    chk("R3 pc_out", pc_out, 8'h00);
  endtask

  task automatic t_plain_in();
    logic [7:0] d;
    bus_write(2'd3, 8'h9B);
    chk("R2 all in pa_oe", pa_oe, 8'h00);
    chk("R2 all in pc_oe", pc_oe, 8'h00);
    pa_in = 8'h33;
    bus_read(2'd0, d);
    chk("R5 read A live", d, 8'h33);
    pa_in = 8'h44;
    bus_read(2'd0, d);
    chk("R5 read A follows pins", d, 8'h44);
    pb_in = 8'h19;
    bus_read(2'd1, d);
    chk("R5 read B live", d, 8'h19);
  endtask

  task automatic t_c_halves();
    logic [7:0] d;
    bus_write(2'd3, 8'h88);
    chk("R7 pc_oe halves", pc_oe, 8'h0F);
    bus_write(2'd2, 8'hA5);
    pc_in = 8'h3C;
    bus_read(2'd2, d);
    chk("R7 read C mixed", d, 8'h35);
  endtask

  task automatic t_bsr();
    bus_write(2'd3, 8'h80);
    bus_write(2'd3, 8'h0D);
    chk("R6 set bit6", pc_out, 8'h40);
    bus_write(2'd3, 8'h01);
    chk("R6 set bit0", pc_out, 8'h41);
    bus_write(2'd3, 8'h0C);
    chk("R6 clear bit6", pc_out, 8'h01);
    chk("R6 cfg kept", pa_oe, 8'hFF);
  endtask

  task automatic t_no_cs();
    logic [7:0] d;
    bus_write(2'd0, 8'h77);
    bus_write(2'd0, 8'h12, 1'b0);
    chk("R9 write ignored", pa_out, 8'h77);
    bus_read(2'd0, d);
    bus_write(2'd1, 8'h21);
    bus_read(2'd1, d, 1'b0);
    chk("R9 read ignored", d, 8'h77);
  endtask

  task automatic t_ctl_read();
    logic [7:0] d;
    bus_read(2'd0, d);
    bus_read(2'd3, d);
    chk("R8 control reads zero", d, 8'h00);
  endtask

  task automatic t_hs_a_in();
    logic [7:0] d;
    pc_in = 8'h10;
    bus_write(2'd3, 8'hB0);
    chk("R10 pc_oe", pc_oe, 8'hEF);
    chk("R10 ibf low", {7'd0, pc_out[5]}, 8'h00);
    pa_in = 8'h77;
    pulse_c(4);
    chk("R10 ibf set", {7'd0, pc_out[5]}, 8'h01);
    release_c(4);
    pa_in = 8'h11;
    bus_read(2'd0, d);
    chk("R10 latched read", d, 8'h77);
    chk("R10 ibf cleared", {7'd0, pc_out[5]}, 8'h00);
    bus_write(2'd0, 8'hEE);
    bus_read(2'd0, d);
    chk("R10 write ignored", d, 8'h77);
  endtask

  task automatic t_hs_b_in();
    logic [7:0] d;
    pc_in = 8'h04;
    bus_write(2'd3, 8'h86);
    chk("R11 pc_oe", pc_oe, 8'hFB);
    pb_in = 8'hA1;
    pulse_c(2);
    chk("R11 ibf set", {7'd0, pc_out[1]}, 8'h01);
    release_c(2);
    pb_in = 8'h00;
    bus_read(2'd1, d);
    chk("R11 latched read", d, 8'hA1);
    chk("R11 ibf cleared", {7'd0, pc_out[1]}, 8'h00);
  endtask

  task automatic t_hs_out();
    pc_in = 8'h44;
    bus_write(2'd3, 8'hA4);
    chk("R12 pc_oe", pc_oe, 8'hBB);
    chk("R12 flags idle", {6'd0, pc_out[7], pc_out[1]}, 8'h03);
    bus_write(2'd0, 8'h3C);
    chk("R12 A data", pa_out, 8'h3C);
    chk("R12 A pending", {7'd0, pc_out[7]}, 8'h00);
    pulse_c(6);
    chk("R12 A acked", {7'd0, pc_out[7]}, 8'h01);
    release_c(6);
    bus_write(2'd1, 8'h5A);
    chk("R12 B pending", {7'd0, pc_out[1]}, 8'h00);
    pulse_c(2);
    chk("R12 B acked", {7'd0, pc_out[1]}, 8'h01);
    release_c(2);
  endtask

  initial begin
    rst = 1'b1; cs = 1'b0; rd = 1'b0; wr = 1'b0; addr = 2'd0; wd = 8'h00;
    pa_in = 8'h00; pb_in = 8'h00; pc_in = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain_out();
    t_mode_clear();
    t_plain_in();
    t_c_halves();
    t_bsr();
    t_no_cs();
    t_ctl_read();
    t_hs_a_in();
    t_hs_b_in();
    t_hs_out();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule